// File: doc/BRIEF.md
# Bucketed Hash Table Unit

This block runs one hash table held in an external word-addressed memory. Every bucket occupies a single 256-bit memory word that is split into four 64-bit slots, and each slot holds one 32-bit key and one 32-bit value. Requests arrive one per cycle at most. An insert places a key/value pair into its bucket by reading the word, merging the pair into it and writing it back. A probe reads the bucket and returns the value stored under the key. The bucket index is the key modulo the table size. Consecutive buckets are spread round-robin over the memory ports, so every port carries part of the table.

The memory side is fully pipelined. A read is issued for each accepted request with no wait for earlier reads to finish. The memory may take tens of cycles to answer, but it must return read words in the order the reads were issued. A small in-flight table keeps the order of outstanding operations. It also holds back any request whose bucket still has an insert that has not written back. A bucket with no free slot is not resolved: the insert is rejected and reported as an out-of-memory overflow.

Top module: `htab_engine`

## Requirements
- R1: After reset the unit is idle: `req_ready` is 1 and `rsp_valid`, `mem_rd_valid` and `mem_wr_valid` are 0.
- R2: A request with key K targets bucket B = K mod NBUCKET. Its memory read is presented on port B mod NPORT at row B div NPORT.
- R3: Slot s of a bucket word occupies bits [64s+63:64s], with the key in the low 32 bits and the value in the high 32 bits. A slot whose key is 0xFFFFFFFF is empty, so that key value is reserved.
- R4: An insert with a free slot writes back the whole bucket with the new pair in the lowest-numbered empty slot and every other slot unchanged. Its response has overflow 0.
- R5: An insert into a bucket with no empty slot produces a response with overflow 1, and no memory write follows.
- R6: A probe returns the value of the lowest-numbered slot whose key equals the probe key, with miss 0. A probe never causes a memory write.
- R7: A probe whose key is in no slot returns miss 1 with value 0.
- R8: Every accepted request yields exactly one response, in the order of acceptance. The read is presented the cycle after acceptance, and the response is presented the cycle after its read data arrives.
- R9: While an accepted insert to bucket B has not yet issued its write, a new request to B is held off (`req_ready` 0). Requests to other buckets are not held off for this reason.
- R10: At most DEPTH requests are outstanding. When DEPTH are outstanding, `req_ready` is 0.
- R11: The write-back of an insert is presented in the same cycle as that insert's response, one cycle after its read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_ins | input | 1 | 1 = insert, 0 = probe |
| req_key | input | 32 | Request key |
| req_val | input | 32 | Value to insert |
| mem_rd_valid | output | 1 | Bucket read request |
| mem_rd_port | output | $clog2(NPORT) | Read port select |
| mem_rd_row | output | $clog2(NBUCKET/NPORT) | Read row within the port |
| mem_rsp_valid | input | 1 | Read data returned (in issue order) |
| mem_rsp_data | input | 256 | Returned bucket word |
| mem_wr_valid | output | 1 | Bucket write-back request |
| mem_wr_port | output | $clog2(NPORT) | Write port select |
| mem_wr_row | output | $clog2(NBUCKET/NPORT) | Write row within the port |
| mem_wr_data | output | 256 | Updated bucket word |
| rsp_valid | output | 1 | Response present |
| rsp_ins | output | 1 | Response belongs to an insert |
| rsp_miss | output | 1 | Probe found no match |
| rsp_ovf | output | 1 | Insert rejected, bucket full |
| rsp_val | output | 32 | Probe result value |

## Verification
The read for an accepted request is due one cycle after acceptance. The response and any write-back are due one cycle after the read word returns, and the memory model answers after a random delay of 20 to 50 cycles. The model tracks the cycle in which it presents each read word and requires `rsp_valid` exactly one cycle later, and never at any other time. A scoreboard queue compares response contents in acceptance order. The held-off and capacity cases are checked by counting the cycles `req_ready` stays low while a request is driven.

// File: rtl/htab_pkg.sv
package htab_pkg;
  localparam int KEY_W  = 32;
  localparam int VAL_W  = 32;
  localparam int SLOT_W = KEY_W + VAL_W;
  localparam logic [KEY_W-1:0] EMPTY_KEY = '1;

  typedef struct packed {
    logic             ins;
    logic [KEY_W-1:0] key;
    logic [VAL_W-1:0] val;
  } op_t;
endpackage

// File: rtl/htab_hash.sv
module htab_hash #(
  parameter int NBUCKET = 64,
  parameter int BKT_W   = $clog2(NBUCKET)
) (
  input  logic [31:0]      key,
  output logic [BKT_W-1:0] bucket
);
  // key modulo table size selects the bucket
  assign bucket = BKT_W'(key % NBUCKET);
endmodule

// File: rtl/htab_split.sv
module htab_split #(
  parameter int NBUCKET = 64,
  parameter int NPORT   = 8,
  parameter int BKT_W   = $clog2(NBUCKET),
  parameter int PORT_W  = $clog2(NPORT),
  parameter int ROW_W   = $clog2(NBUCKET / NPORT)
) (
  input  logic [BKT_W-1:0]  bucket,
  output logic [PORT_W-1:0] port,
  output logic [ROW_W-1:0]  row
);
  generate
    if ((NPORT & (NPORT - 1)) == 0) begin : g_pow2
      assign port = bucket[PORT_W-1:0];
      assign row  = bucket[BKT_W-1:PORT_W];
    end else begin : g_div
      assign port = PORT_W'(bucket % NPORT);
      assign row  = ROW_W'(bucket / NPORT);
    end
  endgenerate
endmodule

// File: rtl/htab_merge.sv
module htab_merge
  import htab_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int WORD_W = SLOTS * SLOT_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic [KEY_W-1:0]  key,
  input  logic [VAL_W-1:0]  val,
  output logic              hit,
  output logic [VAL_W-1:0]  hit_val,
  output logic              has_empty,
  output logic [WORD_W-1:0] new_word
);
  logic [SLOTS-1:0] match;
  logic [SLOTS-1:0] free;
  logic [VAL_W-1:0] vs [SLOTS];

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [KEY_W-1:0] ks;
      assign ks       = word[s*SLOT_W +: KEY_W];
      assign vs[s]    = word[s*SLOT_W+KEY_W +: VAL_W];
      assign free[s]  = (ks == EMPTY_KEY);
      assign match[s] = (ks == key) && !free[s];
    end
  endgenerate

  // lowest-numbered slot wins for both lookup and placement
  always_comb begin
    hit       = 1'b0;
    hit_val   = '0;
    has_empty = 1'b0;
    new_word  = word;
    for (int s = 0; s < SLOTS; s++) begin
      if (match[s] && !hit) begin
        hit     = 1'b1;
        hit_val = vs[s];
      end
      if (free[s] && !has_empty) begin
        has_empty = 1'b1;
        new_word[s*SLOT_W +: SLOT_W] = {val, key};
      end
    end
  end
endmodule

// File: rtl/htab_inflight.sv
module htab_inflight
  import htab_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BKT_W = 6,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  op_t              push_op,
  input  logic [BKT_W-1:0] push_bkt,
  input  logic             pop,
  input  logic [BKT_W-1:0] qry_bkt,
  output logic             full,
  output logic             hazard,
  output op_t              head_op,
  output logic [BKT_W-1:0] head_bkt
);
  op_t              ent_q [DEPTH];
  logic [BKT_W-1:0] bkt_q [DEPTH];
  logic [DEPTH-1:0] occ_q, occ_d;
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PTR_W:0]   cnt_q, cnt_d;
  logic [DEPTH-1:0] hz;

  always_comb begin
    occ_d = occ_q;
    if (push) occ_d[wp_q] = 1'b1;
    if (pop)  occ_d[rp_q] = 1'b0;
    wp_d  = push ? wp_q + 1'b1 : wp_q;
    rp_d  = pop  ? rp_q + 1'b1 : rp_q;
    cnt_d = cnt_q + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      occ_q <= occ_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ent_q[wp_q] <= push_op;
      bkt_q[wp_q] <= push_bkt;
    end
  end

  // an unwritten insert to the same bucket blocks new access
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hz[i] = occ_q[i] && ent_q[i].ins && (bkt_q[i] == qry_bkt);
    end
  endgenerate

  assign hazard   = |hz;
  assign full     = (cnt_q == (PTR_W+1)'(DEPTH));
  assign head_op  = ent_q[rp_q];
  assign head_bkt = bkt_q[rp_q];

  assert_pop_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  assert_push_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/htab_engine.sv
module htab_engine
  import htab_pkg::*;
#(
  parameter int NBUCKET = 64,
  parameter int NPORT   = 8,
  parameter int DEPTH   = 8,
  parameter int SLOTS   = 4,
  parameter int WORD_W  = SLOTS * SLOT_W,
  parameter int BKT_W   = $clog2(NBUCKET),
  parameter int PORT_W  = $clog2(NPORT),
  parameter int ROW_W   = $clog2(NBUCKET / NPORT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ins,
  input  logic [31:0]       req_key,
  input  logic [31:0]       req_val,
  output logic              mem_rd_valid,
  output logic [PORT_W-1:0] mem_rd_port,
  output logic [ROW_W-1:0]  mem_rd_row,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              mem_wr_valid,
  output logic [PORT_W-1:0] mem_wr_port,
  output logic [ROW_W-1:0]  mem_wr_row,
  output logic [WORD_W-1:0] mem_wr_data,
  output logic              rsp_valid,
  output logic              rsp_ins,
  output logic              rsp_miss,
  output logic              rsp_ovf,
  output logic [31:0]       rsp_val
);
  logic             accept, full, hazard;
  logic [BKT_W-1:0] req_bkt, head_bkt;
  op_t              head_op;
  logic             hit, has_empty;
  logic [VAL_W-1:0] hit_val;
  logic [WORD_W-1:0] new_word;

  logic              rd_vld_q, rd_vld_d;
  logic [BKT_W-1:0]  rd_bkt_q;
  logic              rsp_vld_q, rsp_vld_d;
  logic              rsp_ins_q, rsp_miss_q, rsp_ovf_q;
  logic              rsp_miss_d, rsp_ovf_d;
  logic [VAL_W-1:0]  rsp_val_q, rsp_val_d;
  logic              wr_vld_q, wr_vld_d;
  logic [BKT_W-1:0]  wr_bkt_q;
  logic [WORD_W-1:0] wr_data_q;

  htab_hash #(.NBUCKET(NBUCKET), .BKT_W(BKT_W)) u_hash (
    .key(req_key), .bucket(req_bkt));

  htab_inflight #(.DEPTH(DEPTH), .BKT_W(BKT_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_op(op_t'{ins: req_ins, key: req_key, val: req_val}),
    .push_bkt(req_bkt), .pop(mem_rsp_valid), .qry_bkt(req_bkt),
    .full(full), .hazard(hazard), .head_op(head_op), .head_bkt(head_bkt));

  htab_merge #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_merge (
    .word(mem_rsp_data), .key(head_op.key), .val(head_op.val),
    .hit(hit), .hit_val(hit_val), .has_empty(has_empty), .new_word(new_word));

  htab_split #(.NBUCKET(NBUCKET), .NPORT(NPORT), .BKT_W(BKT_W),
               .PORT_W(PORT_W), .ROW_W(ROW_W)) u_rd_map (
    .bucket(rd_bkt_q), .port(mem_rd_port), .row(mem_rd_row));

  htab_split #(.NBUCKET(NBUCKET), .NPORT(NPORT), .BKT_W(BKT_W),
               .PORT_W(PORT_W), .ROW_W(ROW_W)) u_wr_map (
    .bucket(wr_bkt_q), .port(mem_wr_port), .row(mem_wr_row));

  assign req_ready = !full && !hazard;
  assign accept    = req_valid && req_ready;

  always_comb begin
    rd_vld_d   = accept;
    rsp_vld_d  = mem_rsp_valid;
    wr_vld_d   = mem_rsp_valid && head_op.ins && has_empty;
    rsp_miss_d = !head_op.ins && !hit;
    rsp_ovf_d  = head_op.ins && !has_empty;
    rsp_val_d  = (!head_op.ins && hit) ? hit_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rsp_vld_q <= 1'b0;
      wr_vld_q  <= 1'b0;
    end else begin
      rd_vld_q  <= rd_vld_d;
      rsp_vld_q <= rsp_vld_d;
      wr_vld_q  <= wr_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) rd_bkt_q <= req_bkt;
    if (mem_rsp_valid) begin
      rsp_ins_q  <= head_op.ins;
      rsp_miss_q <= rsp_miss_d;
      rsp_ovf_q  <= rsp_ovf_d;
      rsp_val_q  <= rsp_val_d;
      wr_bkt_q   <= head_bkt;
      wr_data_q  <= new_word;
    end
  end

  assign mem_rd_valid = rd_vld_q;
  assign mem_wr_valid = wr_vld_q;
  assign mem_wr_data  = wr_data_q;
  assign rsp_valid    = rsp_vld_q;
  assign rsp_ins      = rsp_ins_q;
  assign rsp_miss     = rsp_miss_q;
  assign rsp_ovf      = rsp_ovf_q;
  assign rsp_val      = rsp_val_q;

  assert_rd_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> $past(req_valid && req_ready));
  assert_wr_after_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> $past(mem_rsp_valid));
  assert_ovf_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ovf) |-> !mem_wr_valid);
  assert_probe_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ins) |-> !mem_wr_valid);
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_val == '0));
endmodule

// File: tb/sim_htab_engine.sv
module sim_htab_engine;
  localparam int NB = 64;
  localparam int NP = 8;
  localparam int DEP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ins = 1'b0;
  logic [31:0] req_key = '0, req_val = '0;
  logic req_ready;
  logic mem_rd_valid, mem_wr_valid;
  logic [2:0] mem_rd_port, mem_wr_port, mem_rd_row, mem_wr_row;
  logic mem_rsp_valid;
  logic [255:0] mem_rsp_data, mem_wr_data;
  logic rsp_valid, rsp_ins, rsp_miss, rsp_ovf;
  logic [31:0] rsp_val;

  htab_engine u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ins(req_ins), .req_key(req_key), .req_val(req_val),
    .mem_rd_valid(mem_rd_valid), .mem_rd_port(mem_rd_port), .mem_rd_row(mem_rd_row),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_port(mem_wr_port), .mem_wr_row(mem_wr_row),
    .mem_wr_data(mem_wr_data), .rsp_valid(rsp_valid), .rsp_ins(rsp_ins),
    .rsp_miss(rsp_miss), .rsp_ovf(rsp_ovf), .rsp_val(rsp_val));

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { bit ins; bit miss; bit ovf; logic [31:0] val; } exp_t;
  exp_t exp_q[$];
  int   bkt_q[$];
  logic [255:0] mem [NB];
  logic [31:0]  rk [NB][4];
  logic [31:0]  rv [NB][4];
  logic [255:0] rdq[$];
  int   dueq[$];
  int   lastdue = 0;
  bit   prev_drv = 0;

  task automatic chk(input string req, input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // memory model and response monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      prev_drv      = 0;
    end else begin
      if (prev_drv || rsp_valid)
        chk("R8", rsp_valid == prev_drv,
            $sformatf("rsp_valid actual=%0d expected=%0d", rsp_valid, prev_drv));
      if (rsp_valid) begin
        exp_t e;
        if (exp_q.size() == 0) chk("R8", 0, "response actual=extra expected=none");
        else begin
          e = exp_q.pop_front();
          chk(e.ins ? (e.ovf ? "R5" : "R4") : (e.miss ? "R7" : "R6"),
              rsp_ins == e.ins && rsp_miss == e.miss && rsp_ovf == e.ovf && rsp_val == e.val,
              $sformatf("ins/miss/ovf/val actual=%0d/%0d/%0d/%h expected=%0d/%0d/%0d/%h",
                        rsp_ins, rsp_miss, rsp_ovf, rsp_val, e.ins, e.miss, e.ovf, e.val));
          chk("R11", mem_wr_valid == (e.ins && !e.ovf),
              $sformatf("mem_wr_valid actual=%0d expected=%0d", mem_wr_valid, e.ins && !e.ovf));
        end
      end else if (mem_wr_valid) chk("R11", 0, "mem_wr_valid actual=1 expected=0");
      if (mem_wr_valid) mem[int'(mem_wr_row) * NP + int'(mem_wr_port)] = mem_wr_data;
      if (mem_rd_valid) begin
        int b, due;
        b = (bkt_q.size() != 0) ? bkt_q.pop_front() : -1;
        chk("R2", int'(mem_rd_port) == b % NP && int'(mem_rd_row) == b / NP,
            $sformatf("port/row actual=%0d/%0d expected=%0d/%0d",
                      mem_rd_port, mem_rd_row, b % NP, b / NP));
        rdq.push_back(mem[int'(mem_rd_row) * NP + int'(mem_rd_port)]);
        due = cyc + int'($urandom_range(50, 20));
        if (due <= lastdue) due = lastdue + 1;
        dueq.push_back(due);
        lastdue = due;
      end
      if (dueq.size() != 0 && dueq[0] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rdq.pop_front();
        void'(dueq.pop_front());
        prev_drv = 1;
      end else begin
        mem_rsp_valid = 1'b0;
        prev_drv = 0;
      end
    end
  end

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic issue(input bit ins, input logic [31:0] key, input logic [31:0] val,
                       output int stalls);
    exp_t e;
    int b;
    bit done;
    stalls = 0;
    req_valid = 1'b1; req_ins = ins; req_key = key; req_val = val;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    b = int'(key % NB);
    e.ins = ins; e.miss = 0; e.ovf = 0; e.val = '0;
    done = 0;
    for (int s = 0; s < 4; s++) begin
      if (!done && ins && rk[b][s] == 32'hFFFF_FFFF) begin
        rk[b][s] = key; rv[b][s] = val; done = 1;
      end
      if (!done && !ins && rk[b][s] == key) begin
        e.val = rv[b][s]; done = 1;
      end
    end
    if (!done) begin
      if (ins) e.ovf = 1; else e.miss = 1;
    end
    exp_q.push_back(e);
    bkt_q.push_back(b);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int st;
    for (int b = 0; b < NB; b++) begin
      mem[b] = '1;
      for (int s = 0; s < 4; s++) begin rk[b][s] = '1; rv[b][s] = '0; end
    end
    // bucket 20: slot 2 preloaded, others empty
    mem[20][191:128] = {32'h0000_ABCD, 32'd20};
    rk[20][2] = 32'd20; rv[20][2] = 32'h0000_ABCD;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", req_ready && !rsp_valid && !mem_rd_valid && !mem_wr_valid,
        $sformatf("ready/rsp/rd/wr actual=%0d/%0d/%0d/%0d expected=1/0/0/0",
                  req_ready, rsp_valid, mem_rd_valid, mem_wr_valid));

    // R3 slot layout: preloaded slot is found, new insert lands in slot 0
    issue(0, 32'd20, 0, st);
    issue(1, 32'd84, 32'h55, st);
    drain();
    chk("R3", mem[20][31:0] == 32'd84 && mem[20][63:32] == 32'h55 &&
              mem[20][191:128] == {32'h0000_ABCD, 32'd20} && mem[20][127:64] == '1,
        $sformatf("bucket20 actual=%h expected slot0=84/55 slot2=20/abcd", mem[20]));
    issue(0, 32'd84, 0, st);   // R4 / R6
    issue(0, 32'd20, 0, st);

    // R2 / R4 / R6: spread of keys, including ones that wrap the table
    for (int i = 0; i < 6; i++) issue(1, 32'(i * 37 + 1), 32'(1000 + i), st);
    issue(1, 32'd70, 32'h7070, st);
    drain();
    for (int i = 0; i < 6; i++) issue(0, 32'(i * 37 + 1), 0, st);
    issue(0, 32'd70, 0, st);
    issue(0, 32'd999, 0, st);   // R7 miss
    issue(0, 32'd6, 0, st);     // R7 miss, same bucket as 70

    // R5: fill bucket 3 and overflow it
    for (int i = 0; i < 5; i++) issue(1, 32'(3 + 64 * i), 32'(300 + i), st);
    issue(0, 32'd259, 0, st);   // rejected key, miss
    issue(0, 32'd195, 0, st);   // fourth slot, hit

    // R6: duplicate key, lowest slot wins
    issue(1, 32'd9, 32'h11, st);
    issue(1, 32'd9, 32'h22, st);
    issue(0, 32'd9, 0, st);
    drain();

    // R9: probe right behind an insert to the same bucket is held off
    issue(1, 32'd10, 32'hA0, st);
    issue(0, 32'd74, 0, st);
    chk("R9", st > 0, $sformatf("stall cycles actual=%0d expected>0", st));
    drain();
    issue(1, 32'd12, 32'hC0, st);
    issue(0, 32'd13, 0, st);
    chk("R9", st == 0, $sformatf("stall cycles actual=%0d expected=0", st));
    issue(0, 32'd14, 0, st);
    issue(1, 32'd14, 32'hE0, st);
    chk("R9", st == 0, $sformatf("insert after probe stall actual=%0d expected=0", st));
    drain();

    // R10: DEPTH outstanding fills the unit
    for (int i = 0; i < DEP; i++) begin
      issue(0, 32'(40 + i), 0, st);
      chk("R10", st == 0, $sformatf("stall below capacity actual=%0d expected=0", st));
    end
    issue(0, 32'd50, 0, st);
    chk("R10", st > 0, $sformatf("stall at capacity actual=%0d expected>0", st));
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule